// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Controller

This block keeps a two-bit coalescing state for each of a set of interrupt sources and decides when a source may send a notification to a downstream router. Message sources raise a one-cycle pulse. Level sources present a line, and that line's rising edge counts as a trigger. A trigger is forwarded only when the source is idle. A trigger that arrives while the source is already forwarded is remembered in the queued bit, so a source is never notified twice before software acknowledges it. When software sends an end-of-interrupt, the block uses that remembered trigger to fire again.

Software reaches each source through its own page in a load/store register window. Loads at fixed offsets inside the page return the previous state and apply a new one in the same access: acknowledge, read, or force a state. Stores inject a trigger or acknowledge. A build parameter selects the page size. With a page shift of 13 or 17, each source's region is split into two halves: a trigger half, where any store injects, and a management half, where the offsets are decoded. Notifications leave on a valid/ready pair that carries the source number.

The per-source states are named RESET (00), OFF (01), PEND (10) and QUEUED (11), where bit 1 is the pending bit and bit 0 is the queued bit. A trigger moves RESET to PEND and forwards. It moves PEND to QUEUED. It leaves QUEUED and OFF unchanged. An acknowledge moves PEND to RESET, and moves QUEUED to PEND and forwards. It leaves OFF and RESET unchanged.

Top module: `pq_src_ctrl`

## Requirements
- R1: After reset, the state of each source equals its two-bit value in `cfg_rst_pq` (source n at bits [2n+1:2n]). `ntf_valid` and `rsp_valid` are low.
- R2: A trigger moves RESET to PEND and forwards the source. It moves PEND to QUEUED. QUEUED and OFF are unchanged. Only RESET to PEND forwards.
- R3: An acknowledge moves QUEUED to PEND and forwards the source again. It moves PEND to RESET without forwarding. OFF and RESET are unchanged.
- R4: Page offsets are decoded from address bits [11:8], and each load sets `rsp_valid` in the next cycle. A load at 0x000–0x3FF acknowledges. Loads at 0x400–0xBFF read the state. A load at 0xC00–0xFFF sets the state to address bits [9:8]. A store at 0x800–0xBFF injects a trigger. A store at 0x400–0x7FF acknowledges. Other stores do nothing, and stores give no response. Every load returns the state held before the access in `rsp_data[1:0]`, with the upper bits zero.
- R5: While `cfg_store_eoi` is low, a store at 0x400–0x7FF leaves the state unchanged.
- R6: Source n occupies addresses n·2^PAGE_SHIFT upward. For PAGE_SHIFT 13 or 17, the management half begins at 2^(PAGE_SHIFT−1) within the source's region. A store in the trigger half injects a trigger. A load in the trigger half returns zero and has no effect.
- R7: For a source whose `cfg_lsi` bit is low, a one-cycle pulse on `src_trig` is a trigger.
- R8: For a source whose `cfg_lsi` bit is high, a rising edge of `src_lvl` is a trigger and `src_trig` is ignored. If the line is still high at an acknowledge that leaves the state at RESET, the source goes to PEND and forwards.
- R9: While `cfg_pq_off` is high, every trigger forwards and leaves the state unchanged.
- R10: A forwarded source waits in a one-deep per-source slot until `ntf_valid && ntf_ready`. The lowest-numbered waiting source is presented first. While `ntf_ready` is low, `ntf_valid` and `ntf_src` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_lsi | input | NUM_SRC | Level mode per source |
| cfg_rst_pq | input | 2·NUM_SRC | Reset state per source |
| cfg_pq_off | input | 1 | Forward every trigger unconditionally |
| cfg_store_eoi | input | 1 | Enable acknowledge by store |
| src_trig | input | NUM_SRC | Message trigger pulses |
| src_lvl | input | NUM_SRC | Level lines |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | PAGE_SHIFT+SRC_W | Byte address inside the window |
| rsp_valid | output | 1 | Load response valid, one cycle after request |
| rsp_data | output | 64 | Previous state in bits [1:0] |
| ntf_valid | output | 1 | Notification valid |
| ntf_ready | input | 1 | Notification accepted |
| ntf_src | output | SRC_W | Source number being notified |

## Verification
If a source held a wrong state, the fault would show at the ports no later than the next load to that source's page, because that load returns the previous state one cycle after the request. It would also show in the notification count: a missing or duplicated notification appears two cycles after the trigger or acknowledge that should or should not have forwarded. A fault in the arbitration shows while `ntf_ready` is held low, either as a changing source number or as a higher source being presented first. The bench walks a chain of register accesses on one source, then checks the level, disable, two-page and stall cases directly.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

    typedef enum logic [1:0] {
        PQ_RESET  = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_QUEUED = 2'b11
    } pq_state_e;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_GET  = 3'd1,
        OP_EOI  = 3'd2,
        OP_INJ  = 3'd3,
        OP_SET  = 3'd4
    } mmio_op_e;

    typedef struct packed {
        logic      fwd;
        pq_state_e nxt;
    } pq_step_t;

    // Trigger step; with the check disabled the trigger always forwards
    function automatic pq_step_t pq_trigger(pq_state_e cur, logic chk_off);
        pq_step_t r;
        r.fwd = 1'b0;
        r.nxt = cur;
        if (chk_off) begin
            r.fwd = 1'b1;
        end else begin
            unique case (cur)
                PQ_RESET:  begin r.nxt = PQ_PEND; r.fwd = 1'b1; end
                PQ_PEND:   r.nxt = PQ_QUEUED;
                PQ_QUEUED: r.nxt = PQ_QUEUED;
                PQ_OFF:    r.nxt = PQ_OFF;
            endcase
        end
        return r;
    endfunction

    // Acknowledge step; the queued bit decides the re-fire
    function automatic pq_step_t pq_eoi(pq_state_e cur);
        pq_step_t r;
        r.fwd = 1'b0;
        r.nxt = cur;
        unique case (cur)
            PQ_QUEUED: begin r.nxt = PQ_PEND; r.fwd = 1'b1; end
            PQ_PEND:   r.nxt = PQ_RESET;
            PQ_OFF:    r.nxt = PQ_OFF;
            PQ_RESET:  r.nxt = PQ_RESET;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pq_mmio_decode.sv
module pq_mmio_decode
    import pq_src_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int SRC_W      = 3,
    parameter int ADDR_W     = PAGE_SHIFT + SRC_W
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              store_eoi_en,
    output mmio_op_e          dec_op,
    output logic [SRC_W-1:0]  dec_src,
    output pq_state_e         dec_set
);
    localparam bit TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

    logic       in_mgmt;
    logic       src_ok;
    logic [3:0] off;
    logic       unused_addr;

    generate
        if (TWO_PAGE) begin : g_two_page
            assign in_mgmt = req_addr[PAGE_SHIFT-1];
        end else begin : g_one_page
            assign in_mgmt = 1'b1;
        end
    endgenerate

    assign off         = req_addr[11:8];
    assign dec_src     = req_addr[PAGE_SHIFT +: SRC_W];
    assign src_ok      = ({1'b0, dec_src} < (SRC_W+1)'(NUM_SRC));
    assign dec_set     = pq_state_e'(off[1:0]);
    assign unused_addr = ^req_addr;

    always_comb begin
        dec_op = OP_NONE;
        if (req_valid && src_ok) begin
            if (!in_mgmt) begin
                if (req_write) dec_op = OP_INJ;
            end else if (req_write) begin
                unique case (off[3:2])
                    2'b01:   dec_op = store_eoi_en ? OP_EOI : OP_NONE;
                    2'b10:   dec_op = OP_INJ;
                    default: dec_op = OP_NONE;
                endcase
            end else begin
                unique case (off[3:2])
                    2'b00:   dec_op = OP_EOI;
                    2'b11:   dec_op = OP_SET;
                    default: dec_op = OP_GET;
                endcase
            end
        end
    end
endmodule

// File: rtl/pq_src_cell.sv
module pq_src_cell
    import pq_src_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] rst_pq,
    input  logic      is_lsi,
    input  logic      pq_off,
    input  logic      trig,
    input  logic      lvl,
    input  mmio_op_e  op,
    input  pq_state_e set_val,
    output pq_state_e state_q,
    output logic      fwd
);
    pq_state_e state_d;
    logic      asserted_q;
    logic      hw_trig;

    assign hw_trig = is_lsi ? (lvl && !asserted_q) : trig;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= pq_state_e'(rst_pq);
            asserted_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            asserted_q <= is_lsi && lvl;
        end
    end

    // Next state: the register access first, then the hardware trigger
    always_comb begin
        pq_step_t  st_a;
        pq_step_t  st_b;
        pq_state_e s1;
        logic      f1;
        s1   = state_q;
        f1   = 1'b0;
        st_a = '{fwd: 1'b0, nxt: state_q};
        unique case (op)
            OP_EOI: begin
                st_a = pq_eoi(state_q);
                s1   = st_a.nxt;
                f1   = st_a.fwd;
                if (is_lsi && asserted_q && s1 == PQ_RESET) begin
                    s1 = PQ_PEND;
                    f1 = 1'b1;
                end
            end
            OP_INJ: begin
                st_a = pq_trigger(state_q, pq_off);
                s1   = st_a.nxt;
                f1   = st_a.fwd;
            end
            OP_SET:  s1 = set_val;
            default: s1 = state_q;
        endcase
        st_b = '{fwd: 1'b0, nxt: s1};
        if (hw_trig) st_b = pq_trigger(s1, pq_off);
        state_d = st_b.nxt;
        fwd     = f1 || st_b.fwd;
    end

    p_off_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_SET && state_q == PQ_OFF) |=> state_q == PQ_OFF);

    p_queued_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_SET && state_q == PQ_QUEUED) |=> (state_q == PQ_PEND || state_q == PQ_QUEUED));

    p_leave_idle_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) == PQ_RESET && state_q == PQ_PEND && $past(op) != OP_SET)
        |-> $past(fwd));
endmodule

// File: rtl/pq_notify_arb.sv
module pq_notify_arb #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] fwd,
    input  logic               ntf_ready,
    output logic               ntf_valid,
    output logic [SRC_W-1:0]   ntf_src
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] take;
    logic [SRC_W-1:0]   pick;
    logic               load;

    assign load = !ntf_valid || ntf_ready;

    always_comb begin
        pick = '0;
        for (int i = NUM_SRC-1; i >= 0; i--) begin
            if (pend_q[i]) pick = SRC_W'(i);
        end
        take = '0;
        if (load && |pend_q) take[pick] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= '0;
            ntf_valid <= 1'b0;
            ntf_src   <= '0;
        end else begin
            pend_q <= (pend_q & ~take) | fwd;
            if (load) begin
                ntf_valid <= |pend_q;
                ntf_src   <= pick;
            end
        end
    end

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_src)));
endmodule

// File: rtl/pq_src_ctrl.sv
module pq_src_ctrl
    import pq_src_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    parameter int ADDR_W     = PAGE_SHIFT + SRC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   cfg_lsi,
    input  logic [2*NUM_SRC-1:0] cfg_rst_pq,
    input  logic                 cfg_pq_off,
    input  logic                 cfg_store_eoi,
    input  logic [NUM_SRC-1:0]   src_trig,
    input  logic [NUM_SRC-1:0]   src_lvl,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic [63:0]          rsp_data,
    output logic                 ntf_valid,
    input  logic                 ntf_ready,
    output logic [SRC_W-1:0]     ntf_src
);
    mmio_op_e           dec_op;
    logic [SRC_W-1:0]   dec_src;
    pq_state_e          dec_set;
    pq_state_e          cur_pq [NUM_SRC];
    mmio_op_e           cell_op [NUM_SRC];
    logic [NUM_SRC-1:0] fwd;

    pq_mmio_decode #(
        .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
    ) u_dec (
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .store_eoi_en(cfg_store_eoi),
        .dec_op(dec_op), .dec_src(dec_src), .dec_set(dec_set)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign cell_op[i] = (dec_src == SRC_W'(i)) ? dec_op : OP_NONE;
            pq_src_cell u_cell (
                .clk(clk), .rst_n(rst_n),
                .rst_pq(cfg_rst_pq[2*i +: 2]),
                .is_lsi(cfg_lsi[i]), .pq_off(cfg_pq_off),
                .trig(src_trig[i]), .lvl(src_lvl[i]),
                .op(cell_op[i]), .set_val(dec_set),
                .state_q(cur_pq[i]), .fwd(fwd[i])
            );
        end
    endgenerate

    pq_notify_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .fwd(fwd),
        .ntf_ready(ntf_ready), .ntf_valid(ntf_valid), .ntf_src(ntf_src)
    );

    // Load response: previous state, captured in the cycle of the access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_data  <= (dec_op == OP_NONE) ? 64'd0 : {62'd0, cur_pq[dec_src]};
        end
    end

    p_load_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    p_store_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);
endmodule

// File: tb/pq_src_ctrl_tb.sv
`timescale 1ns/1ps
module pq_src_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [7:0]  cfg_lsi = 8'h08;
    logic [15:0] cfg_rst_pq = 16'h0004;
    logic        cfg_pq_off = 1'b0;
    logic        cfg_store_eoi = 1'b1;
    logic [7:0]  src_trig = '0;
    logic [7:0]  src_lvl = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        ntf_valid, ntf_ready = 1'b1;
    logic [2:0]  ntf_src;

    logic        req2_valid = 1'b0, req2_write = 1'b0;
    logic [15:0] req2_addr = '0;
    logic        rsp2_valid;
    logic [63:0] rsp2_data;
    logic        ntf2_valid;
    logic [2:0]  ntf2_src;

    pq_src_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_lsi(cfg_lsi), .cfg_rst_pq(cfg_rst_pq),
        .cfg_pq_off(cfg_pq_off), .cfg_store_eoi(cfg_store_eoi),
        .src_trig(src_trig), .src_lvl(src_lvl),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_src(ntf_src));

    pq_src_ctrl #(.PAGE_SHIFT(13)) u_dut_2p (
        .clk(clk), .rst_n(rst_n), .cfg_lsi(8'h00), .cfg_rst_pq(16'h0000),
        .cfg_pq_off(1'b0), .cfg_store_eoi(1'b1),
        .src_trig(8'h00), .src_lvl(8'h00),
        .req_valid(req2_valid), .req_write(req2_write), .req_addr(req2_addr),
        .rsp_valid(rsp2_valid), .rsp_data(rsp2_data),
        .ntf_valid(ntf2_valid), .ntf_ready(1'b1), .ntf_src(ntf2_src));

    int checks = 0, errors = 0;
    int ncnt [8] = '{default: 0};
    int ncnt2 = 0;

    always @(posedge clk) begin
        if (ntf_valid && ntf_ready) ncnt[ntf_src] <= ncnt[ntf_src] + 1;
        if (ntf2_valid) ncnt2 <= ncnt2 + 1;
    end

    // {store, offset[11:0], expected previous state, expected notifications}
    localparam logic [15:0] VEC [18] = '{
        {1'b0, 12'h800, 2'b00, 1'b0}, {1'b1, 12'h800, 2'b00, 1'b1},
        {1'b0, 12'h800, 2'b10, 1'b0}, {1'b1, 12'h800, 2'b00, 1'b0},
        {1'b1, 12'h800, 2'b00, 1'b0}, {1'b0, 12'h800, 2'b11, 1'b0},
        {1'b0, 12'h000, 2'b11, 1'b1}, {1'b0, 12'h800, 2'b10, 1'b0},
        {1'b0, 12'h000, 2'b10, 1'b0}, {1'b0, 12'h800, 2'b00, 1'b0},
        {1'b0, 12'hD00, 2'b00, 1'b0}, {1'b1, 12'h800, 2'b00, 1'b0},
        {1'b0, 12'h000, 2'b01, 1'b0}, {1'b0, 12'hF00, 2'b01, 1'b0},
        {1'b0, 12'hE00, 2'b11, 1'b0}, {1'b1, 12'h400, 2'b00, 1'b0},
        {1'b0, 12'hC00, 2'b00, 1'b0}, {1'b0, 12'h800, 2'b00, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mmio(input bit two, input bit wr, input logic [15:0] addr,
                        output logic [63:0] data);
        @(negedge clk);
        if (two) begin
            req2_valid = 1'b1; req2_write = wr; req2_addr = addr;
        end else begin
            req_valid = 1'b1; req_write = wr; req_addr = addr[14:0];
        end
        @(negedge clk);
        req_valid = 1'b0; req2_valid = 1'b0;
        data = two ? rsp2_data : rsp_data;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk);
        src_trig = m;
        @(negedge clk);
        src_trig = '0;
    endtask

    function automatic logic [15:0] a1(input int s, input logic [11:0] off);
        return 16'((s << 12) | off);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] d;
        int c0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R1 ntf_valid after reset", 64'(ntf_valid), 64'd0);
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        mmio(0, 0, a1(1, 12'h800), d);
        chk("R1 programmed reset state of source 1", d, 64'h1);

        // Table walk on source 0
        for (int i = 0; i < 18; i++) begin
            c0 = ncnt[0];
            mmio(0, VEC[i][15], a1(0, VEC[i][14:3]), d);
            if (!VEC[i][15]) chk($sformatf("R4 table prev step %0d", i), d, 64'(VEC[i][2:1]));
            idle(4);
            chk($sformatf("R2 R3 table notify step %0d", i), 64'(ncnt[0] - c0), 64'(VEC[i][0]));
        end

        // R7 edge trigger input
        pulse(8'h04);
        idle(4);
        chk("R7 edge trigger notifies", 64'(ncnt[2]), 64'd1);
        pulse(8'h04);
        idle(4);
        chk("R7 second edge coalesced", 64'(ncnt[2]), 64'd1);
        mmio(0, 0, a1(2, 12'h800), d);
        chk("R7 state queued", d, 64'h3);

        // R8 level source 3
        @(negedge clk); src_lvl[3] = 1'b1;
        idle(4);
        chk("R8 rising level notifies", 64'(ncnt[3]), 64'd1);
        mmio(0, 0, a1(3, 12'h000), d);
        chk("R8 eoi prev pending", d, 64'h2);
        idle(4);
        chk("R8 eoi while asserted re-fires", 64'(ncnt[3]), 64'd2);
        @(negedge clk); src_lvl[3] = 1'b0;
        mmio(0, 0, a1(3, 12'h000), d);
        idle(4);
        chk("R8 eoi after release silent", 64'(ncnt[3]), 64'd2);
        pulse(8'h08);
        idle(4);
        mmio(0, 0, a1(3, 12'h800), d);
        chk("R8 message pulse ignored on level source", d, 64'h0);
        chk("R8 no notify from pulse", 64'(ncnt[3]), 64'd2);

        // R9 check disabled
        cfg_pq_off = 1'b1;
        pulse(8'h10); idle(4);
        pulse(8'h10); idle(4);
        cfg_pq_off = 1'b0;
        chk("R9 every trigger forwards", 64'(ncnt[4]), 64'd2);
        mmio(0, 0, a1(4, 12'h800), d);
        chk("R9 state untouched", d, 64'h0);

        // R5 store acknowledge disabled
        cfg_store_eoi = 1'b0;
        mmio(0, 0, a1(0, 12'hE00), d);
        mmio(0, 1, a1(0, 12'h400), d);
        mmio(0, 0, a1(0, 12'h800), d);
        chk("R5 store eoi ignored when disabled", d, 64'h2);
        cfg_store_eoi = 1'b1;

        // R6 page mapping, single page
        mmio(0, 1, a1(7, 12'h800), d);
        idle(4);
        chk("R6 inject on page 7 notifies 7", 64'(ncnt[7]), 64'd1);
        mmio(0, 0, a1(6, 12'h800), d);
        chk("R6 neighbour page 6 untouched", d, 64'h0);

        // R6 two-page layout (shift 13)
        mmio(1, 0, 16'h2800, d);
        chk("R6 trigger-page load returns zero", d, 64'h0);
        mmio(1, 1, 16'h2000, d);
        idle(4);
        chk("R6 trigger-page store injects", 64'(ncnt2), 64'd1);
        mmio(1, 0, 16'h2000, d);
        mmio(1, 0, 16'h3800, d);
        chk("R6 management page reads pending", d, 64'h2);

        // R10 backpressure and ordering
        ntf_ready = 1'b0;
        pulse(8'h60);
        idle(4);
        chk("R10 valid while stalled", 64'(ntf_valid), 64'd1);
        chk("R10 lowest source first", 64'(ntf_src), 64'd5);
        idle(3);
        chk("R10 source held while stalled", 64'(ntf_src), 64'd5);
        chk("R10 nothing accepted while stalled", 64'(ncnt[5] + ncnt[6]), 64'd0);
        ntf_ready = 1'b1;
        idle(5);
        chk("R10 both delivered after release", 64'(ncnt[5] + ncnt[6]), 64'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule